// File: doc/BRIEF.md
# USB Bulk OUT Endpoint Receiver

This block takes in the data stage of bulk OUT transfers for one endpoint and answers each packet with a handshake request. A packet decoder ahead of it supplies events that are already decoded: a pulse when an OUT token matches this endpoint, a strobe for each data byte, an end-of-packet pulse that carries a CRC verdict, and a timeout pulse. Bytes go into a 64-entry FIFO. A local processor drains the FIFO through a read port and watches a byte count, an empty flag and a set of sticky status bits. It can enable any status bit to pull the active-low interrupt line.

A packet succeeds when it is not stalled, never overran the FIFO and ends with a good CRC. Such a packet requests ACK. A packet that overran requests NAK. A packet that ends with a bad CRC or times out gets no handshake. When retries are enabled, the bytes of a failed packet are taken back out of the FIFO by restoring the write pointer saved at the token, and earlier unread data is kept. When retries are off, the bytes stay in the FIFO and the packet-received bit is set so that the processor can discard them. While stalled, the endpoint stores nothing and requests STALL.

Top module: `usb_bulk_out_ep`

## Requirements
- R1: A cycle with `tok_out` high sets status bit 0 (token seen) and opens a packet.
- R2: Stored bytes leave the FIFO in arrival order. `rd_data` shows the oldest byte, `rd_en` removes it on the clock edge, and `rd_en` on an empty FIFO has no effect.
- R3: A data byte that arrives while `byte_cnt` is 64 is dropped and sets status bit 2 (NAK sent). If that packet ends with a good CRC, `hs_nak` pulses instead of `hs_ack`.
- R4: While `stall` is high, no byte of the packet is stored and status bit 4 is not set. An end-of-packet pulse gives a one-cycle `hs_stall`.
- R5: `byte_cnt` equals the number of unread bytes in the FIFO, and `fifo_empty` is high exactly when that number is zero.
- R6: Status bit 5 (almost full) is set on every cycle in which `af_thresh` is nonzero and `byte_cnt` is at least `af_thresh`.
- R7: A successful packet sets status bits 1 (ACK sent) and 4 (packet received) and pulses `hs_ack` for one cycle. This happens one clock after the end-of-packet pulse.
- R8: A failed packet with `retry_en` low sets status bit 4 and leaves its bytes in the FIFO.
- R9: A failed packet with `retry_en` high does not set status bit 4. Its unread bytes are removed, and bytes of earlier packets stay in the FIFO.
- R10: A bad CRC at end of packet, or a `rx_timeout` pulse, fails the packet with no handshake pulse. A timeout also sets status bit 3 and ends the packet.
- R11: Writing 1 to a bit of `status_clr` clears that status bit. A set event in the same cycle takes priority.
- R12: `irq_n` is low exactly when some status bit and its `irq_en` bit are both 1.
- R13: `rx_valid` is ignored outside a packet and in any cycle that also carries `rx_eop` or `rx_timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_out | input | 1 | OUT token for this endpoint recognised |
| rx_valid | input | 1 | Data byte strobe |
| rx_data | input | 8 | Data byte |
| rx_eop | input | 1 | End of data packet |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_eop |
| rx_timeout | input | 1 | Packet timed out |
| rd_en | input | 1 | Pop one byte from the FIFO |
| rd_data | output | 8 | Oldest unread byte |
| byte_cnt | output | 7 | Unread byte count |
| fifo_empty | output | 1 | FIFO holds no bytes |
| status | output | 6 | Sticky status bits |
| status_clr | input | 6 | Write-one-to-clear strobes |
| irq_en | input | 6 | Per-bit interrupt enables |
| af_thresh | input | 7 | Almost-full threshold, 0 disables |
| stall | input | 1 | Endpoint stalled |
| retry_en | input | 1 | Automatic rollback of failed packets |
| hs_ack | output | 1 | ACK handshake request |
| hs_nak | output | 1 | NAK handshake request |
| hs_stall | output | 1 | STALL handshake request |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The processor's FIFO read and the end-of-packet rollback can fall in the same cycle. So can a read and a byte write into a full FIFO, and a read can also remove bytes of the packet that is still being received. The bench issues reads at random, with random probability, on every cycle of a packet, including the cycle that ends it. It judges each cycle against a queue model. In that model the read pops the head first, a byte arriving while the pre-cycle count is 64 is dropped, and a rollback deletes only those bytes of the failing packet that are still unread.

// File: rtl/usb_bulk_out_ep.sv
module usb_bulk_out_ep #(
  parameter int DEPTH = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tok_out,
  input  logic                      rx_valid,
  input  logic [7:0]                rx_data,
  input  logic                      rx_eop,
  input  logic                      rx_crc_ok,
  input  logic                      rx_timeout,
  input  logic                      rd_en,
  output logic [7:0]                rd_data,
  output logic [$clog2(DEPTH):0]    byte_cnt,
  output logic                      fifo_empty,
  output logic [5:0]                status,
  input  logic [5:0]                status_clr,
  input  logic [5:0]                irq_en,
  input  logic [$clog2(DEPTH):0]    af_thresh,
  input  logic                      stall,
  input  logic                      retry_en,
  output logic                      hs_ack,
  output logic                      hs_nak,
  output logic                      hs_stall,
  output logic                      irq_n
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

  logic [7:0]  mem [DEPTH];
  logic [AW:0] wr_ptr, rd_ptr, wr_save, plen;
  logic        in_pkt, ovf;

  assign byte_cnt   = wr_ptr - rd_ptr;
  assign fifo_empty = byte_cnt == '0;
  assign rd_data    = mem[rd_ptr[AW-1:0]];
  assign irq_n      = ~|(status & irq_en);

  wire do_rd    = rd_en && !fifo_empty;
  wire data_cyc = in_pkt && rx_valid && !rx_eop && !rx_timeout;
  wire full     = byte_cnt == CAP;
  wire do_wr    = data_cyc && !stall && !full;
  wire drop     = data_cyc && !stall && full;
  wire fin      = in_pkt && (rx_eop || rx_timeout);
  wire eop_only = fin && !rx_timeout;
  wire good     = eop_only && rx_crc_ok && !ovf && !stall;
  wire failed   = fin && !stall && !good;
  wire rollback = failed && retry_en;
  wire nak_hs   = eop_only && rx_crc_ok && ovf && !stall;
  wire stall_hs = eop_only && stall;

  wire [AW:0] rd_inc  = rd_ptr + {{AW{1'b0}}, do_rd};
  wire [AW:0] rd_over = rd_inc - wr_save;
  wire        back_rd = rd_over != '0 && rd_over <= plen;

  wire [5:0] set_v = {
    af_thresh != '0 && byte_cnt >= af_thresh,
    good || (failed && !retry_en),
    fin && rx_timeout,
    drop,
    good,
    tok_out
  };

  always_ff @(posedge clk)
    if (do_wr) mem[wr_ptr[AW-1:0]] <= rx_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      wr_save  <= '0;
      plen     <= '0;
      in_pkt   <= 1'b0;
      ovf      <= 1'b0;
      status   <= '0;
      hs_ack   <= 1'b0;
      hs_nak   <= 1'b0;
      hs_stall <= 1'b0;
    end else begin
      hs_ack   <= good;
      hs_nak   <= nak_hs;
      hs_stall <= stall_hs;
      status   <= (status & ~status_clr) | set_v;
      rd_ptr   <= rd_inc;
      if (do_wr) begin
        wr_ptr <= wr_ptr + 1'b1;
        plen   <= plen + 1'b1;
      end
      if (drop) ovf <= 1'b1;
      if (rollback) begin
        wr_ptr <= wr_save;
        if (back_rd) rd_ptr <= wr_save;
      end
      if (fin) in_pkt <= 1'b0;
      if (tok_out) begin
        in_pkt  <= 1'b1;
        wr_save <= wr_ptr;
        plen    <= '0;
        ovf     <= 1'b0;
      end
    end
  end
endmodule

module usb_bulk_out_ep_chk #(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   stall,
  input logic [$clog2(DEPTH):0] byte_cnt,
  input logic [5:0]             status,
  input logic                   hs_ack,
  input logic                   hs_nak,
  input logic                   hs_stall
);
  p_hs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hs_ack, hs_nak, hs_stall}));
  p_ack_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hs_ack |-> status[1] && status[4]);
  p_nak_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_nak |-> status[2]);
  p_stall_no_grow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> byte_cnt <= $past(byte_cnt));
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    byte_cnt <= ($clog2(DEPTH)+1)'(DEPTH));
endmodule

bind usb_bulk_out_ep usb_bulk_out_ep_chk #(.DEPTH(DEPTH)) chk_i (.*);

// File: tb/usb_bulk_out_ep_tb_top.sv
module usb_bulk_out_ep_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tok = 0, v = 0, eop = 0, crc = 0, tmo = 0, rd = 0, stall = 0, retry = 0;
  logic [7:0] d = 0, rd_data;
  logic [6:0] byte_cnt, thresh = 0;
  logic [5:0] status, clr = 0, ien = 0;
  logic fifo_empty, hs_ack, hs_nak, hs_stall, irq_n;
  int tests = 0, fails = 0;

  byte unsigned q[$];
  int cur = 0;
  bit m_in = 0, m_ovf = 0, ea = 0, en = 0, es = 0;
  logic [5:0] m_stat = 0;

  always #4 clk = ~clk;

  usb_bulk_out_ep dut_i (
    .clk(clk), .rst_n(rst_n), .tok_out(tok), .rx_valid(v), .rx_data(d),
    .rx_eop(eop), .rx_crc_ok(crc), .rx_timeout(tmo), .rd_en(rd),
    .rd_data(rd_data), .byte_cnt(byte_cnt), .fifo_empty(fifo_empty),
    .status(status), .status_clr(clr), .irq_en(ien), .af_thresh(thresh),
    .stall(stall), .retry_en(retry), .hs_ack(hs_ack), .hs_nak(hs_nak),
    .hs_stall(hs_stall), .irq_n(irq_n));

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(byte_cnt == 7'(q.size()), "R5 byte_cnt", byte_cnt, q.size());
    chk(fifo_empty == (q.size() == 0), "R5 fifo_empty", fifo_empty, q.size() == 0);
    chk(status == m_stat, "R11 status", status, m_stat);
    chk({hs_ack, hs_nak, hs_stall} == {ea, en, es}, "R7 handshake",
        {hs_ack, hs_nak, hs_stall}, {ea, en, es});
    chk(irq_n == !(|(m_stat & ien)), "R12 irq_n", irq_n, !(|(m_stat & ien)));
  endtask

  task automatic step(bit t, bit vv, byte unsigned dd, bit e, bit c, bit to, bit r, logic [5:0] cl);
    int sz;
    bit fin, good;
    logic [5:0] setv;
    @(negedge clk);
    tok = t; v = vv; d = dd; eop = e; crc = c; tmo = to; rd = r; clr = cl;
    if (r && q.size() > 0) chk(rd_data == q[0], "R2 rd_data", rd_data, q[0]);
    sz = q.size();
    setv = 0; ea = 0; en = 0; es = 0;
    if (thresh != 0 && sz >= thresh) setv[5] = 1;
    if (r && sz > 0) begin
      if (sz == cur && cur > 0) cur--;
      void'(q.pop_front());
    end
    if (m_in && vv && !e && !to && !stall) begin
      if (sz == 64) begin m_ovf = 1; setv[2] = 1; end
      else begin q.push_back(dd); cur++; end
    end
    fin = m_in && (e || to);
    if (fin) begin
      m_in = 0;
      good = e && !to && c && !m_ovf && !stall;
      if (to) setv[3] = 1;
      if (stall) es = e && !to;
      else if (good) begin setv[1] = 1; setv[4] = 1; ea = 1; end
      else begin
        en = e && !to && c && m_ovf;
        if (retry) repeat (cur) void'(q.pop_back());
        else setv[4] = 1;
      end
      cur = 0;
    end
    if (t) begin m_in = 1; cur = 0; m_ovf = 0; setv[0] = 1; end
    m_stat = (m_stat & ~cl) | setv;
    @(posedge clk); #1;
    compare();
  endtask

  task automatic idle(int n, bit r);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, r, 0);
  endtask

  task automatic send_pkt(int len, int endm, int rdp, int gapp);
    int i;
    step(1, 0, 0, 0, 0, 0, ($urandom % 100) < rdp, 0);
    i = 0;
    while (i < len) begin
      if (($urandom % 100) < gapp) step(0, 0, 0, 0, 0, 0, ($urandom % 100) < rdp, 0);
      else begin
        step(0, 1, 8'($urandom), 0, 0, 0, ($urandom % 100) < rdp, 0);
        i++;
      end
    end
    step(0, $urandom % 2, 8'($urandom), endm != 2, endm == 0, endm == 2,
         ($urandom % 100) < rdp, 0);
  endtask

  task automatic drain();
    while (q.size() > 0) step(0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #1200000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #2;
    compare();   // reset state, R5 R12

    // R13 data outside a packet ignored, R2 read on empty ignored
    step(0, 1, 8'h55, 0, 0, 0, 1, 0);
    // R1 token, R7 success packet, R2 ordering
    ien = 6'h3f;
    send_pkt(10, 0, 0, 0);
    idle(2, 0);
    step(0, 0, 0, 0, 0, 0, 0, 6'h3f);   // R11 clear all, R12 irq released
    drain();
    // R3 overflow -> NAK, R8 data kept with retries off
    send_pkt(70, 0, 0, 0);
    idle(1, 0);
    drain();
    // R4 stall
    stall = 1;
    send_pkt(12, 0, 0, 0);
    stall = 0;
    idle(1, 0);
    // R9 bad CRC with retries on keeps earlier data, R10 no handshake
    retry = 1;
    send_pkt(5, 0, 0, 0);
    send_pkt(20, 1, 0, 0);
    idle(1, 0);
    // R10 timeout, R9 rollback while reading into the packet
    send_pkt(8, 2, 90, 0);
    drain();
    // R6 almost full threshold
    thresh = 7'd6;
    send_pkt(9, 0, 0, 0);
    idle(2, 0);
    thresh = 0;
    drain();
    // R11 set wins over clear in the same cycle
    step(1, 0, 0, 0, 0, 0, 0, 6'h01);
    step(0, 0, 0, 1, 1, 0, 0, 6'h3f);
    idle(1, 0);

    // random phase
    for (int p = 0; p < 220; p++) begin
      stall  = ($urandom % 8) == 0;
      retry  = $urandom % 2;
      thresh = 7'($urandom % 72);
      ien    = 6'($urandom);
      send_pkt(1 + $urandom % 80, $urandom % 4 == 3 ? 1 + $urandom % 2 : 0,
               $urandom % 60, $urandom % 30);
      step(0, 0, 0, 0, 0, 0, $urandom % 2, 6'($urandom));
      if (($urandom % 4) == 0) drain();
    end
    stall = 0;
    drain();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule